// File: doc/BRIEF.md
# Burst ROM Read Controller

This block runs the bus side of a read from a burst ROM whose access time does not depend on the clock. It sits on a 32-bit data bus. A single request moves one 16-byte line as four 32-bit beats. The first beat waits for the full access time of the ROM. The three beats after it only wait the shorter page access time, so each beat has its own count of wait cycles.

The requester pulses `req_i` with a line address and two wait counts. The controller first holds the address for one setup cycle with the bus-start strobe active. It then runs the first wait phase and captures the first beat. Each later beat gets its own wait phase and capture cycle. A closing cycle follows the fourth beat. Chip select, read strobe and DMA acknowledge stay active through the whole burst. An active-low WAIT input lets the memory stretch any wait phase. Each captured word is returned with a one-cycle valid pulse, and a one-cycle done pulse ends the transaction.

Top module: `burst_rom_rd`

## Requirements
- R1: After reset `bus_cs_no`, `bus_rd_no`, `bus_bs_no` and `bus_dack_no` are 1, and `busy_o`, `rvalid_o` and `done_o` are 0.
- R2: A burst starts with exactly one setup cycle. In that cycle `bus_bs_no` is 0, and it is the first cycle with `bus_cs_no` at 0. `bus_cs_no` then stays 0 without a gap through the closing cycle.
- R3: With first-beat wait F (0..7, from `first_wait_i`), the first capture cycle is the (F+2)-th cycle of the burst, counting the setup cycle as the first.
- R4: With later-beat wait N (0..3, from `next_wait_i`), each of beats 1..3 is captured N+1 cycles after the previous beat's capture cycle.
- R5: `bus_wait_ni` is sampled only in the last cycle of a wait phase. While it is 0 there, the phase repeats that cycle, so k such cycles add exactly k cycles. In the setup, capture and closing cycles it has no effect.
- R6: `bus_addr_o` carries the request address with bits 3:0 replaced: bits 1:0 are 0 and bits 3:2 hold the beat index 0,1,2,3 in order. Bits above 3 stay fixed for the whole burst.
- R7: `bus_data_i` is sampled at the end of each capture cycle. It appears on `rdata_o` with `rvalid_o` at 1 for exactly the next cycle, in beat order.
- R8: The closing cycle comes directly after the fourth capture cycle. `done_o` is 1 for exactly the cycle after it, and `busy_o` is 1 from the setup cycle through the closing cycle.
- R9: `bus_rd_no` and `bus_dack_no` equal `bus_cs_no` in every cycle. `bus_rdwr_o` is always 1 (read).
- R10: `req_i` while busy starts nothing. Changes to `base_addr_i`, `first_wait_i` and `next_wait_i` after the request cycle do not affect the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a line read; taken only when idle |
| base_addr_i | input | 24 | Line address; bits 3:0 ignored |
| first_wait_i | input | 3 | Wait cycles before the first beat |
| next_wait_i | input | 2 | Wait cycles before each later beat |
| busy_o | output | 1 | Burst in progress |
| rdata_o | output | 32 | Captured beat |
| rvalid_o | output | 1 | `rdata_o` valid for one cycle |
| done_o | output | 1 | One-cycle pulse after the burst |
| bus_addr_o | output | 24 | Memory address |
| bus_data_i | input | 32 | Memory read data |
| bus_wait_ni | input | 1 | Wait request from memory, active low |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_rdwr_o | output | 1 | Direction, 1 = read |
| bus_bs_no | output | 1 | Bus-start strobe, active low |
| bus_dack_no | output | 1 | DMA acknowledge, active low |

## Verification
The checker watches the strobe relations in every cycle:
- the bus-start pulse is single and opens the chip-select window;
- read strobe and acknowledge follow chip select;
- the address stays aligned and the upper address stays stable during a burst;
- valid pulses fall inside a burst;
- done is a single pulse that closes one.

Only the bench scenarios can show the exact cycle counts of each wait phase, the stretch caused by WAIT, the data order, and that mid-burst requests and configuration changes are ignored. For those, the bench sweeps all first/later wait pairs and places WAIT windows at computed cycles.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_SETUP      = 3'd1,
    S_FIRST_WAIT = 3'd2,
    S_BEAT       = 3'd3,
    S_NEXT_WAIT  = 3'd4,
    S_CLOSE      = 3'd5
  } brr_state_e;
endpackage

// File: rtl/brr_wait_timer.sv
module brr_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i && cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  // holds at 1 so an external wait can repeat the last cycle
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/brr_addr_gen.sv
module brr_addr_gen #(
  parameter int ADDR_W = 24,
  parameter int BEATS  = 4,
  parameter int OFS_W  = 2,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int LOW_W  = BEAT_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_beat_o
);
  logic [ADDR_W-LOW_W-1:0] upper_q;
  logic [BEAT_W-1:0]       beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      beat_q  <= '0;
    end else if (start_i) begin
      upper_q <= base_i[ADDR_W-1:LOW_W];
      beat_q  <= '0;
    end else if (step_i) begin
      beat_q  <= beat_q + BEAT_W'(1);
    end
  end

  assign addr_o      = {upper_q, beat_q, {OFS_W{1'b0}}};
  assign last_beat_o = (beat_q == BEAT_W'(BEATS - 1));
endmodule

// File: rtl/brr_capture.sv
module brr_capture #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= take_i;
      if (take_i) rdata_o <= data_i;
    end
  end
endmodule

// File: rtl/brr_fsm.sv
module brr_fsm
  import brr_pkg::*;
#(
  parameter int FW_W  = 3,
  parameter int NW_W  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [FW_W-1:0]  first_wait_i,
  input  logic [NW_W-1:0]  next_wait_i,
  input  logic             wait_ni,
  input  logic             tmr_last_i,
  input  logic             last_beat_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             tmr_run_o,
  output logic             start_o,
  output logic             step_o,
  output logic             take_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             rd_no,
  output logic             bs_no,
  output logic             dack_no
);
  brr_state_e state_q, state_d;
  logic [FW_W-1:0] fw_q;
  logic [NW_W-1:0] nw_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    tmr_run_o  = 1'b0;
    start_o    = 1'b0;
    step_o     = 1'b0;
    take_o     = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        start_o = 1'b1;
        state_d = S_SETUP;
      end
      S_SETUP: begin
        if (fw_q == '0) state_d = S_BEAT;
        else begin
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(fw_q);
          state_d    = S_FIRST_WAIT;
        end
      end
      S_FIRST_WAIT, S_NEXT_WAIT: begin
        tmr_run_o = 1'b1;
        if (tmr_last_i && wait_ni) state_d = S_BEAT;
      end
      S_BEAT: begin
        take_o = 1'b1;
        if (last_beat_i) state_d = S_CLOSE;
        else begin
          step_o = 1'b1;
          if (nw_q == '0) state_d = S_BEAT;
          else begin
            tmr_load_o = 1'b1;
            tmr_val_o  = CNT_W'(nw_q);
            state_d    = S_NEXT_WAIT;
          end
        end
      end
      S_CLOSE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fw_q    <= '0;
      nw_q    <= '0;
      done_o  <= 1'b0;
      cs_no   <= 1'b1;
      rd_no   <= 1'b1;
      bs_no   <= 1'b1;
      dack_no <= 1'b1;
    end else begin
      state_q <= state_d;
      if (start_o) begin
        fw_q <= first_wait_i;
        nw_q <= next_wait_i;
      end
      done_o  <= (state_q == S_CLOSE);
      // strobes registered from next state: aligned with state_q, glitch free
      cs_no   <= (state_d == S_IDLE);
      rd_no   <= (state_d == S_IDLE);
      dack_no <= (state_d == S_IDLE);
      bs_no   <= (state_d != S_SETUP);
    end
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/burst_rom_rd.sv
module burst_rom_rd #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int FW_W   = 3,
  parameter int NW_W   = 2,
  localparam int OFS_W = $clog2(DATA_W / 8),
  localparam int CNT_W = (FW_W > NW_W) ? FW_W : NW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [FW_W-1:0]   first_wait_i,
  input  logic [NW_W-1:0]   next_wait_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_wait_ni,
  output logic              bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_rdwr_o,
  output logic              bus_bs_no,
  output logic              bus_dack_no
);
  logic             tmr_load, tmr_run, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             start, step, take, last_beat;

  brr_fsm #(.FW_W(FW_W), .NW_W(NW_W), .CNT_W(CNT_W)) i_fsm (
    .clk_i, .rst_ni, .req_i, .first_wait_i, .next_wait_i,
    .wait_ni     (bus_wait_ni),
    .tmr_last_i  (tmr_last),
    .last_beat_i (last_beat),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .tmr_run_o   (tmr_run),
    .start_o     (start),
    .step_o      (step),
    .take_o      (take),
    .busy_o, .done_o,
    .cs_no       (bus_cs_no),
    .rd_no       (bus_rd_no),
    .bs_no       (bus_bs_no),
    .dack_no     (bus_dack_no)
  );

  brr_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .last_o     (tmr_last)
  );

  brr_addr_gen #(.ADDR_W(ADDR_W), .BEATS(BEATS), .OFS_W(OFS_W)) i_addr (
    .clk_i, .rst_ni,
    .start_i     (start),
    .base_i      (base_addr_i),
    .step_i      (step),
    .addr_o      (bus_addr_o),
    .last_beat_o (last_beat)
  );

  brr_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i, .rst_ni,
    .take_i   (take),
    .data_i   (bus_data_i),
    .rdata_o, .rvalid_o
  );

  assign bus_rdwr_o = 1'b1;
endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_cs_no,
  input logic              bus_rd_no,
  input logic              bus_bs_no,
  input logic              bus_dack_no,
  input logic              rvalid_o,
  input logic              done_o
);
  assert_bs_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_bs_no |-> !bus_cs_no);
  assert_bs_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_bs_no |=> bus_bs_no);
  assert_bs_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_no) |-> !bus_bs_no);
  assert_rd_tracks_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_no == bus_cs_no);
  assert_dack_tracks_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_dack_no == bus_cs_no);
  assert_addr_aligned_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cs_no |-> bus_addr_o[1:0] == 2'b00);
  assert_upper_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && !$past(bus_cs_no)) |-> $stable(bus_addr_o[ADDR_W-1:4]));
  assert_rvalid_in_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !$past(bus_cs_no));
  assert_done_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bus_cs_no && !$past(bus_cs_no));
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind burst_rom_rd brr_checker #(.ADDR_W(ADDR_W)) i_brr_checker (
  .clk_i, .rst_ni, .bus_addr_o, .bus_cs_no, .bus_rd_no,
  .bus_bs_no, .bus_dack_no, .rvalid_o, .done_o
);

// File: tb/test_burst_rom_rd.sv
module test_burst_rom_rd;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [23:0] base_addr_i = '0;
  logic [2:0]  first_wait_i = '0;
  logic [1:0]  next_wait_i = '0;
  logic        busy_o, rvalid_o, done_o;
  logic [31:0] rdata_o, bus_data_i;
  logic [23:0] bus_addr_o;
  logic        bus_wait_ni = 1'b1;
  logic        bus_cs_no, bus_rd_no, bus_rdwr_o, bus_bs_no, bus_dack_no;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  burst_rom_rd i_burst_rom_rd (.*);

  function automatic logic [31:0] rom_word(input logic [23:0] a);
    return {8'hC3 ^ a[7:0], a};
  endfunction

  assign bus_data_i = rom_word(bus_addr_o);

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_burst(input int fw, input int nw, input int xf, input int xl,
                           input bit hold, input logic [23:0] base);
    int tb2[4];
    int cs_cnt = 0, bs_cnt = 0, strobe_bad = 0, rdwr_bad = 0, nbeat = 0;
    int bs_k = -1, done_k = -1, w2;
    logic [23:0] al;
    al = {base[23:4], 4'h0};
    tb2[0] = 1 + fw + xf;
    tb2[1] = tb2[0] + nw + 1 + xl;
    tb2[2] = tb2[1] + nw + 1;
    tb2[3] = tb2[2] + nw + 1;
    w2 = tb2[0] + nw;
    @(negedge clk_i);
    req_i = 1'b1; base_addr_i = base;
    first_wait_i = 3'(fw); next_wait_i = 2'(nw);
    @(negedge clk_i);
    req_i = 1'b0; base_addr_i = ~base;          // R10: late changes ignored
    first_wait_i = 3'(7 - fw); next_wait_i = 2'(3 - nw);
    for (int k = 0; k < 300; k++) begin
      if (k > 0) @(negedge clk_i);
      if (!bus_cs_no) cs_cnt++;
      if (!bus_bs_no) begin bs_cnt++; bs_k = k; end
      if (bus_rd_no != bus_cs_no || bus_dack_no != bus_cs_no) strobe_bad++;
      if (!bus_rdwr_o) rdwr_bad++;
      if (rvalid_o) begin
        if (nbeat < 4) begin
          chk(k == tb2[nbeat] + 1, nbeat == 0 ? "R3" : "R4", "beat cycle", k, tb2[nbeat] + 1);
          chk(rdata_o == rom_word(al + 24'(4 * nbeat)), "R6/R7 data", "beat word",
              rdata_o, rom_word(al + 24'(4 * nbeat)));
        end
        nbeat++;
      end
      if (done_o) begin done_k = k; break; end
      // R5: WAIT windows at the last cycle of each wait phase, or held everywhere
      bus_wait_ni = 1'b1;
      if (hold) bus_wait_ni = 1'b0;
      if (xf > 0 && k >= fw && k < fw + xf) bus_wait_ni = 1'b0;
      if (xl > 0 && k >= w2 && k < w2 + xl) bus_wait_ni = 1'b0;
      req_i = (k == 3);                          // R10: request while busy
    end
    bus_wait_ni = 1'b1;
    req_i = 1'b0;
    chk(done_k == tb2[3] + 2, "R8", "done cycle", done_k, tb2[3] + 2);
    chk(cs_cnt == tb2[3] + 2, hold ? "R5" : "R2", "cs low cycles", cs_cnt, tb2[3] + 2);
    chk(bs_cnt == 1 && bs_k == 0, "R2", "bs pulse", bs_cnt, 1);
    chk(nbeat == 4, "R7", "beat count", nbeat, 4);
    chk(strobe_bad == 0 && rdwr_bad == 0, "R9", "strobe mismatches", strobe_bad + rdwr_bad, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i);
      chk(bus_cs_no && !busy_o && !done_o, "R10", "no restart", bus_cs_no, 1);
    end
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(bus_cs_no && bus_rd_no && bus_bs_no && bus_dack_no, "R1", "strobes in reset",
        {bus_cs_no, bus_rd_no, bus_bs_no, bus_dack_no}, 4'hF);
    chk(!busy_o && !rvalid_o && !done_o, "R1", "status in reset",
        {busy_o, rvalid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(bus_cs_no && !busy_o && !rvalid_o && !done_o, "R1", "idle after reset", bus_cs_no, 1);
    for (int fw = 0; fw < 8; fw++)
      for (int nw = 0; nw < 4; nw++) begin
        run_burst(fw, nw, 0, 0, 1'b0, 24'(24'h12340F + fw * 24'h1010 + nw * 24'h33));
        if (fw > 0) run_burst(fw, nw, 2, 0, 1'b0, 24'(24'hA5F003 + fw * 24'h40));
        if (nw > 0) run_burst(fw, nw, 0, 3, 1'b0, 24'(24'h0BEEF7 + nw * 24'h100));
      end
    run_burst(0, 0, 0, 0, 1'b1, 24'hFFFFFF);     // R5: WAIT outside wait phases
    finish_run();
  end
endmodule